// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block gathers a fixed set of interrupt request lines and presents one request at a time to a processor core. A rising edge on a request line records that request as pending. Each source carries a programmable priority level and a mask bit. When several requests are pending, the controller picks one by level and then by a fixed per-source rank. It drives a request to the core together with the source index and that source's level.

The controller tracks which priority levels are in service. A pending request reaches the core only when its level is strictly more urgent than every level already in service, and only while the global enable flag is set. Accepting a request clears that flag, so nesting happens only after software issues an enable command inside the handler. An end-of-service command retires the most urgent level in service. The remaining pending requests are then weighed against the levels still open.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A 0-to-1 transition on `req_i[s]` marks source s pending from the following clock. Further edges on a source that is already pending are not counted, so one acceptance retires all of them.
- R2: A source whose mask bit is 1 can still become pending but never wins arbitration. Clearing its mask lets the held request be offered.
- R3: Among unmasked pending sources, the one with the numerically smallest level wins. Level 0 is the most urgent, and levels 0 to 7 are programmable through the 3-bit level field.
- R4: Among unmasked pending sources at equal level, the one with the lower source index wins, whatever order they arrived in.
- R5: `irq_o` is 1 only while the global enable `gie_o` is 1. `ei_i` sets the enable and `di_i` clears it. When both are given in the same cycle, the disable takes effect. Requests that arrive while the enable is 0 stay pending.
- R6: `ack_i` while `irq_o` is 1 does three things in one clock: it clears the winner's pending bit, it sets in-service bit `in_svc_o[irq_lvl_o]`, and it clears `gie_o`.
- R7: While any level is in service, a candidate is offered only if its level is strictly smaller than the smallest in-service level. A request at an equal or less urgent level is held.
- R8: `eos_i` clears the in-service bit with the smallest index. Held requests are then judged against the remaining in-service levels.
- R9: After reset, no source is pending, `in_svc_o` is 0, `gie_o` is 0 and `irq_o` is 0. Every source is at level 7 with its mask bit set.
- R10: While `irq_o` is 1, `vec_o` gives the winning source index and `irq_lvl_o` gives its programmed level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Request lines, edge-detected |
| cfg_we_i | input | 1 | Writes level and mask of one source |
| cfg_idx_i | input | IDX_W | Source selected by the write |
| cfg_lvl_i | input | LVL_W | Level to write (0 most urgent) |
| cfg_mask_i | input | 1 | Mask bit to write (1 = masked) |
| ei_i | input | 1 | Enable command |
| di_i | input | 1 | Disable command |
| ack_i | input | 1 | Core accepts the offered request |
| eos_i | input | 1 | End-of-service command |
| irq_o | output | 1 | Request to the core |
| vec_o | output | IDX_W | Winning source index |
| irq_lvl_o | output | LVL_W | Level of the winning source |
| gie_o | output | 1 | Global enable flag |
| in_svc_o | output | 2**LVL_W | In-service bit per level |

## Verification
The hardest state to reach from the ports has two levels in service at once, with held requests at both an equal and a less urgent level. Reaching it needs a sequence: an accepted request, an explicit enable inside its service, then arrivals at the same level, a worse level and a better level. The bench builds that sequence step by step. It then retires the services one by one to see the held requests released in level order. A sweep over every ordered pair of sources, with levels computed from the pair indices, covers level wins and index tie-breaks. Each pair is taken through acceptance, the hold at equal-or-worse level, and release at end of service.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  // index of the least significant set bit, 0 when none
  function automatic int unsigned low_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             mask_i,
  output logic [LVL_W-1:0] lvl_o [N_SRC],
  output logic [N_SRC-1:0] mask_o
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic [LVL_W-1:0] lvl_q;
    logic             mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q  <= '1;
        mask_q <= 1'b1;
      end else if (we_i && (idx_i == IDX_W'(s))) begin
        lvl_q  <= lvl_i;
        mask_q <= mask_i;
      end
    end
    assign lvl_o[s]  = lvl_q;
    assign mask_o[s] = mask_q;
  end
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic req_q, pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        req_q  <= req_i[s];
        // a fresh edge wins over a same-cycle clear
        pend_q <= (pend_q & ~clr_i[s]) | (req_i[s] & ~req_q);
      end
    end
    assign pend_o[s] = pend_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] elig_i,
  input  logic [LVL_W-1:0] lvl_i [N_SRC],
  output logic             found_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic [LVL_W-1:0] win_lvl_o
);
  // ascending scan with strict compare keeps the lower index on ties
  always_comb begin
    found_o   = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig_i[i] && (!found_o || (lvl_i[i] < win_lvl_o))) begin
        found_o   = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import nest_irq_pkg::*;
#(
  parameter int LVL_W = 3,
  localparam int NLVL = 1 << LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_fire_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic             eos_i,
  input  logic             ei_i,
  input  logic             di_i,
  output logic [NLVL-1:0]  in_svc_o,
  output logic             top_vld_o,
  output logic [LVL_W-1:0] top_lvl_o,
  output logic             gie_o
);
  logic [NLVL-1:0] svc_q, clr_v, set_v;
  logic            gie_q;

  assign top_vld_o = |svc_q;
  assign top_lvl_o = LVL_W'(low_set(32'(svc_q)));

  always_comb begin
    clr_v = '0;
    set_v = '0;
    if (eos_i && top_vld_o) clr_v[top_lvl_o] = 1'b1;
    if (ack_fire_i)         set_v[ack_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q <= '0;
      gie_q <= 1'b0;
    end else begin
      svc_q <= (svc_q & ~clr_v) | set_v;
      if (ack_fire_i || di_i) gie_q <= 1'b0;
      else if (ei_i)          gie_q <= 1'b1;
    end
  end

  assign in_svc_o = svc_q;
  assign gie_o    = gie_q;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int NLVL  = 1 << LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [LVL_W-1:0] cfg_lvl_i,
  input  logic             cfg_mask_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             ack_i,
  input  logic             eos_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] vec_o,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic             gie_o,
  output logic [NLVL-1:0]  in_svc_o
);
  logic [LVL_W-1:0] lvl_w [N_SRC];
  logic [N_SRC-1:0] mask_w, pend_w, clr_w;
  logic             found_w, top_vld_w, preempt_ok, ack_fire;
  logic [IDX_W-1:0] win_idx_w;
  logic [LVL_W-1:0] win_lvl_w, top_lvl_w;

  irq_cfg_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .lvl_i(cfg_lvl_i), .mask_i(cfg_mask_i),
    .lvl_o(lvl_w), .mask_o(mask_w)
  );

  irq_pend_latch #(.N_SRC(N_SRC)) u_pend (
    .clk_i, .rst_ni, .req_i, .clr_i(clr_w), .pend_o(pend_w)
  );

  irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .elig_i(pend_w & ~mask_w), .lvl_i(lvl_w),
    .found_o(found_w), .win_idx_o(win_idx_w), .win_lvl_o(win_lvl_w)
  );

  irq_svc_track #(.LVL_W(LVL_W)) u_svc (
    .clk_i, .rst_ni,
    .ack_fire_i(ack_fire), .ack_lvl_i(win_lvl_w),
    .eos_i, .ei_i, .di_i,
    .in_svc_o, .top_vld_o(top_vld_w), .top_lvl_o(top_lvl_w), .gie_o
  );

  assign preempt_ok = !top_vld_w || (win_lvl_w < top_lvl_w);
  assign irq_o      = gie_o && found_w && preempt_ok;
  assign ack_fire   = ack_i && irq_o;
  assign vec_o      = win_idx_w;
  assign irq_lvl_o  = win_lvl_w;

  always_comb begin
    clr_w = '0;
    if (ack_fire) clr_w[win_idx_w] = 1'b1;
  end
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int NLVL  = 1 << LVL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             ack_i,
  input logic             eos_i,
  input logic             gie_o,
  input logic [IDX_W-1:0] vec_o,
  input logic [LVL_W-1:0] irq_lvl_o,
  input logic [NLVL-1:0]  in_svc_o,
  input logic [N_SRC-1:0] mask_i
);
  logic [LVL_W:0] hi_lvl;
  always_comb begin
    hi_lvl = LVL_W'(NLVL) + 1'b0;
    for (int l = NLVL - 1; l >= 0; l--) if (in_svc_o[l]) hi_lvl = (LVL_W + 1)'(l);
  end

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_o); // R5
  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mask_i[vec_o]); // R2
  AST_ACK_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (!gie_o && in_svc_o[$past(irq_lvl_o)])); // R6
  AST_PREEMPT_STRICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && (|in_svc_o)) |-> ({1'b0, irq_lvl_o} < hi_lvl)); // R7
  AST_EOS_RETIRES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && !ack_i && (|in_svc_o)) |=>
      ($countones(in_svc_o) == $countones($past(in_svc_o)) - 1)); // R8
endmodule

bind nest_irq_ctrl nest_irq_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .ack_i(ack_i), .eos_i(eos_i),
  .gie_o(gie_o), .vec_o(vec_o), .irq_lvl_o(irq_lvl_o), .in_svc_o(in_svc_o),
  .mask_i(mask_w)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  localparam int N = 8;
  localparam int LW = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic cfg_we_i = 0, cfg_mask_i = 0, ei_i = 0, di_i = 0, ack_i = 0, eos_i = 0;
  logic [2:0] cfg_idx_i = '0;
  logic [LW-1:0] cfg_lvl_i = '0;
  logic irq_o, gie_o;
  logic [2:0] vec_o;
  logic [LW-1:0] irq_lvl_o;
  logic [7:0] in_svc_o;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #10 clk_i = ~clk_i;

  nest_irq_ctrl #(.N_SRC(N), .LVL_W(LW)) u0 (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int lvl, input bit m);
    cfg_we_i = 1; cfg_idx_i = 3'(idx); cfg_lvl_i = LW'(lvl); cfg_mask_i = m;
    tick();
    cfg_we_i = 0;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    req_i = v; tick(); req_i = '0; tick();
  endtask

  task automatic cmd_ei();  ei_i = 1;  tick(); ei_i = 0;  endtask
  task automatic cmd_ack(); ack_i = 1; tick(); ack_i = 0; endtask
  task automatic cmd_eos(); eos_i = 1; tick(); eos_i = 0; endtask

  initial begin
    tick(); tick();
    rst_ni = 1; tick();
    // R9 reset state
    chk(irq_o, 0, "R9 irq");
    chk(gie_o, 0, "R9 gie");
    chk(in_svc_o, 0, "R9 in_svc");
    cmd_ei();
    pulse(8'h01);
    chk(irq_o, 0, "R9 masked by default");
    ei_i = 1; di_i = 1; tick(); ei_i = 0; di_i = 0;
    chk(gie_o, 0, "R5 disable wins");
    cfg(0, 7, 0);
    chk(irq_o, 0, "R5 held while disabled");
    cmd_ei();
    chk(irq_o, 1, "R9 level7 after unmask");
    chk(irq_lvl_o, 7, "R9 default level");
    cmd_ack(); cmd_eos();

    // R3 R4 R10 R6 R7 R8 pair sweep
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        int la, lb, w, o, lw, lo;
        if (a == b) continue;
        la = (a + 2 * b) % 4;
        lb = (b + 2 * a) % 4;
        cfg(a, la, 0); cfg(b, lb, 0);
        pulse((8'h1 << a) | (8'h1 << b));
        chk(irq_o, 0, "R5 pending while disabled");
        cmd_ei();
        if (la < lb || (la == lb && a < b)) begin w = a; o = b; lw = la; lo = lb; end
        else begin w = b; o = a; lw = lb; lo = la; end
        chk(irq_o, 1, "R3 offer");
        chk(vec_o, w, (la == lb) ? "R4 tie vec" : "R3 level vec");
        chk(irq_lvl_o, lw, "R10 level");
        cmd_ack();
        chk(gie_o, 0, "R6 gie cleared");
        chk(in_svc_o, 1 << lw, "R6 in_svc");
        cmd_ei();
        chk(irq_o, 0, "R7 equal or worse held");
        cmd_eos();
        chk(in_svc_o, 0, "R8 retire");
        chk(irq_o, 1, "R8 released");
        chk(vec_o, o, "R8 released vec");
        chk(irq_lvl_o, lo, "R10 released level");
        cmd_ack(); cmd_eos();
        chk(irq_o, 0, "R1 nothing left");
      end
    end

    // R7 R8 nesting scenario
    for (int s = 0; s < N; s++) cfg(s, 7, 1);
    cfg(2, 2, 0); cfg(5, 1, 0); cfg(6, 2, 0); cfg(1, 3, 0);
    pulse(8'h04); cmd_ei();
    chk(vec_o, 2, "R7 first");
    cmd_ack(); cmd_ei();
    pulse(8'h40);
    chk(irq_o, 0, "R7 equal level held");
    pulse(8'h02);
    chk(irq_o, 0, "R7 worse level held");
    pulse(8'h20);
    chk(irq_o, 1, "R7 better level nests");
    chk(vec_o, 5, "R7 nest vec");
    cmd_ack();
    chk(in_svc_o, 8'h06, "R6 two levels open");
    cmd_eos();
    chk(in_svc_o, 8'h04, "R8 most urgent retired");
    cmd_ei();
    chk(irq_o, 0, "R8 still blocked by level2");
    cmd_eos();
    chk(irq_o, 1, "R8 release after last");
    chk(vec_o, 6, "R8 level order");
    cmd_ack(); cmd_eos(); cmd_ei();
    chk(vec_o, 1, "R8 worst last");
    cmd_ack(); cmd_eos();

    // R2 mask sweep
    for (int s = 0; s < N; s++) begin
      cfg(s, s % 8, 1);
      pulse(8'h1 << s);
      cmd_ei();
      chk(irq_o, 0, "R2 masked held");
      cfg(s, s % 8, 0);
      chk(irq_o, 1, "R2 unmask offers");
      chk(vec_o, s, "R2 vec");
      cmd_ack(); cmd_eos();
      cfg(s, 7, 1);
    end

    // R1 repeated edges
    cfg(4, 0, 0);
    pulse(8'h10); pulse(8'h10); pulse(8'h10);
    cmd_ei();
    chk(irq_o, 1, "R1 pending");
    cmd_ack(); cmd_eos(); cmd_ei();
    chk(irq_o, 0, "R1 repeats not counted");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule